// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a byte-wide asynchronous serial transmitter and receiver driven by a small register interface. Software chooses the line rate from a thirteen-entry rate code table and sets the character format: 7 or 8 data bits, no parity or odd or even parity, and one or two stop bits. A byte written to the data address goes into a one-byte holding register. From there it passes to a shift register and leaves least significant bit first on `txd`. Incoming characters on `rxd` are sampled at the middle of each bit and placed into a one-byte receive register. A receive-ready interrupt request stays high until software reads that register.

The command register holds the direction enables, a break control, and the two modem control outputs. Writing a 1 to the command error-clear bit is a one-shot action that clears the sticky parity, framing and overrun flags. The status register reports those flags, the transmitter and receiver state, and the level of the modem `dsr_i` input.

The internal bit clock is a tick at 16 times the chosen rate. It is produced by dividing the system clock `CLK_HZ` by a rounded divisor.

Top module: `async_serial_port`

## Requirements
- R1: After reset `txd` is 1, `rts_o`, `dtr_o` and `irq_o` are 0, both directions are disabled, and status (address 1) reads 0x05 when `dsr_i` is 0.
- R2: Rate codes 0..12 written to address 3 select 110, 150, 300, 600, 1200, 2400, 4800, 9600, 1200, 75, 19200, 38400 and 200 baud. Codes 13..15 select 9600. One bit lasts 16 × round(CLK_HZ / (16 × rate)) clock cycles.
- R3: Each transmitted character is a start bit 0, then the data bits LSB first, then an optional parity bit, then the stop bits (all 1). The mode register (write address 1) uses bit 2 for 8 data bits (else 7) and bit 7 for two stop bits.
- R4: Mode bit 4 enables parity. Mode bit 5 selects even parity when set and odd when clear. A received parity bit that does not match sets status bit 3.
- R5: Status bit 0 (transmit ready) is 1 when the holding register is empty. Status bit 2 (transmitter empty) is 1 only when both the holding register and the shift register are idle.
- R6: Command bit 0 enables the transmitter. A byte written while this bit is clear waits in the holding register and `txd` stays high until the bit is set.
- R7: Command bit 3 holds `txd` at 0 for as long as it is set.
- R8: When receive is enabled, a completed character sets status bit 1 and `irq_o`. Reading address 0 returns the byte, with bit 7 zero in 7-bit mode, and clears both.
- R9: A character that completes while receive ready is still set is discarded. It sets overrun status bit 4 and leaves the held byte unchanged.
- R10: A received character whose first stop bit samples 0 sets framing error status bit 5.
- R11: Writing command (address 2) with bit 4 set clears status bits 3, 4 and 5. The clear wins over a flag set in the same cycle, and bit 4 is not stored.
- R12: Command bit 5 drives `rts_o`, command bit 1 drives `dtr_o`, and status bit 7 reflects `dsr_i`.
- R13: Command bit 2 enables the receiver. While it is clear, activity on `rxd` leaves receive ready and `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 data, 1 status/mode, 2 command, 3 rate code |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading address 0 consumes the byte) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |
| dsr_i | input | 1 | Modem data-set-ready input |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| irq_o | output | 1 | Receive-ready interrupt request |

## Verification
The hardest state to reach from the ports is an overrun. A second complete character must finish while the first is still unread. The bench reaches it by driving two whole frames back to back on `rxd` with no read in between, then checks that the flag is set and that the first byte survives.

The second hardest case is a two-stop-bit frame, because its second stop bit is indistinguishable from an idle line. The bench separates the two by reading status in the middle of that bit and confirming the transmitter still reports busy.

Rate selection is confirmed by measuring a single high data bit in clock cycles at three codes, including the slowest one.

// File: rtl/serial_pkg.sv
package serial_pkg;

  localparam int DIV_W   = 16;
  localparam int FRAME_W = 12;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;
  localparam logic [1:0] A_RATE = 2'd3;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_e;

  function automatic int unsigned rate_for(input logic [3:0] code);
    case (code)
      4'd0:    return 110;
      4'd1:    return 150;
      4'd2:    return 300;
      4'd3:    return 600;
      4'd4:    return 1200;
      4'd5:    return 2400;
      4'd6:    return 4800;
      4'd7:    return 9600;
      4'd8:    return 1200;
      4'd9:    return 75;
      4'd10:   return 19200;
      4'd11:   return 38400;
      4'd12:   return 200;
      default: return 9600;
    endcase
  endfunction

  // Rounded divide of the system clock down to sixteen ticks per bit.
  function automatic logic [DIV_W-1:0] divisor_for(input logic [3:0] code,
                                                   input int unsigned clk_hz);
    int unsigned r;
    int unsigned d;
    r = rate_for(code);
    d = (clk_hz + 8 * r) / (16 * r);
    if (d == 0) d = 1;
    if (d > (1 << DIV_W) - 1) d = (1 << DIV_W) - 1;
    return d[DIV_W-1:0];
  endfunction

  function automatic logic parity_bit(input logic [7:0] d, input logic eight,
                                      input logic even);
    logic x;
    x = eight ? ^d : ^d[6:0];
    return even ? x : ~x;
  endfunction

  // Line bits in send order starting at index 0; unused upper bits are 1.
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d,
      input logic eight, input logic par_en, input logic even);
    logic [FRAME_W-1:0] f;
    int nd;
    f  = '1;
    nd = eight ? 8 : 7;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < nd) f[1+i] = d[i];
    if (par_en) f[1+nd] = parity_bit(d, eight, even);
    return f;
  endfunction

  function automatic logic [3:0] frame_len(input logic eight, input logic par_en,
                                           input logic two_stop);
    return 4'd1 + (eight ? 4'd8 : 4'd7) + {3'b0, par_en} + (two_stop ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/serial_baud_gen.sv
module serial_baud_gen
  import serial_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_228_800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code,
  output logic       tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = divisor_for(code, CLK_HZ) - {{(DIV_W-1){1'b0}}, 1'b1};
  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + {{(DIV_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       eight,
  input  logic       par_en,
  input  logic       even,
  input  logic       two_stop,
  output logic       line,
  output logic       hold_empty,
  output logic       shift_idle,
  output logic       load_evt
);
  logic [7:0]         hold;
  logic               full;
  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         left;
  logic [3:0]         tcnt;
  logic               bit_end;

  assign load_evt   = en && full && !busy;
  assign bit_end    = busy && tick && (tcnt == 4'd15);
  assign line       = busy ? sh[0] : 1'b1;
  assign hold_empty = !full;
  assign shift_idle = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
    end else begin
      if (wr) begin
        hold <= wdata;
        full <= 1'b1;
      end else if (load_evt) begin
        full <= 1'b0;
      end
      if (load_evt) begin
        busy <= 1'b1;
        sh   <= build_frame(hold, eight, par_en, even);
        left <= frame_len(eight, par_en, two_stop);
        tcnt <= '0;
      end else if (busy && tick) begin
        tcnt <= tcnt + 4'd1;
        if (bit_end) begin
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd,
  input  logic       eight,
  input  logic       par_en,
  input  logic       even,
  input  logic       rd_clr,
  input  logic       err_clr,
  output logic [7:0] data,
  output logic       ready,
  output logic       fe,
  output logic       pe,
  output logic       oe,
  output logic       complete_evt,
  output logic       overrun_evt
);
  logic [2:0] sync;
  logic       line;
  rx_state_e  state;
  logic [3:0] tcnt;
  logic [3:0] idx;
  logic [7:0] sh;
  logic       par_rx;
  logic [3:0] nd;
  logic [3:0] stop_idx;
  logic       start_evt;
  logic       sample_evt;
  logic [7:0] frame_data;
  logic       par_bad;

  assign line       = sync[1];
  assign nd         = eight ? 4'd8 : 4'd7;
  assign stop_idx   = nd + {3'b0, par_en};
  assign start_evt  = (state == RX_IDLE) && en && sync[2] && !line;
  assign sample_evt = (state == RX_DATA) && tick && (tcnt == 4'd15);
  assign complete_evt = sample_evt && (idx == stop_idx);
  assign overrun_evt  = complete_evt && ready && !rd_clr;
  assign frame_data = eight ? sh : {1'b0, sh[6:0]};
  assign par_bad    = par_en && (par_rx != parity_bit(sh, eight, even));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync   <= '1;
      state  <= RX_IDLE;
      tcnt   <= '0;
      idx    <= '0;
      sh     <= '0;
      par_rx <= 1'b0;
    end else begin
      sync <= {sync[1:0], rxd};
      case (state)
        RX_IDLE: if (start_evt) begin
          state <= RX_START;
          tcnt  <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt == 4'd7) begin
            state <= line ? RX_IDLE : RX_DATA;
            tcnt  <= '0;
            idx   <= '0;
          end else begin
            tcnt <= tcnt + 4'd1;
          end
        end
        default: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (sample_evt) begin
            idx <= idx + 4'd1;
            if (idx < nd) sh[idx[2:0]] <= line;
            if (par_en && idx == nd) par_rx <= line;
            if (complete_evt) state <= RX_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      ready <= 1'b0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      oe    <= 1'b0;
    end else begin
      if (complete_evt && !overrun_evt) begin
        data  <= frame_data;
        ready <= 1'b1;
      end else if (rd_clr) begin
        ready <= 1'b0;
      end
      if (err_clr) begin
        fe <= 1'b0;
        pe <= 1'b0;
        oe <= 1'b0;
      end else begin
        if (complete_evt && !line) fe <= 1'b1;
        if (complete_evt && par_bad) pe <= 1'b1;
        if (overrun_evt) oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import serial_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_228_800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       dsr_i,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       irq_o
);
  logic       two_stop, even, par_en, eight;
  logic       rts_q, brk, rx_en, dtr_q, tx_en;
  logic [3:0] rate_q;

  logic       tick;
  logic       tx_wr, tx_load, tx_line, hold_empty, shift_idle;
  logic       tx_ready, tx_empty;
  logic       rx_rd, err_clr;
  logic [7:0] rx_data;
  logic       rx_ready, fe, pe, oe, rx_complete, overrun_evt;
  logic [7:0] status;

  assign tx_wr   = wr_en && (addr == A_DATA);
  assign rx_rd   = rd_en && (addr == A_DATA);
  assign err_clr = wr_en && (addr == A_CMD) && wdata[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {two_stop, even, par_en, eight} <= '0;
      {rts_q, brk, rx_en, dtr_q, tx_en} <= '0;
      rate_q <= 4'd7;
    end else if (wr_en) begin
      case (addr)
        A_STAT: {two_stop, even, par_en, eight} <= {wdata[7], wdata[5], wdata[4], wdata[2]};
        A_CMD:  {rts_q, brk, rx_en, dtr_q, tx_en} <= {wdata[5], wdata[3], wdata[2], wdata[1], wdata[0]};
        A_RATE: rate_q <= wdata[3:0];
        default: ;
      endcase
    end
  end

  serial_baud_gen #(.CLK_HZ(CLK_HZ)) u_baud (
    .clk(clk), .rst_n(rst_n), .code(rate_q), .tick(tick)
  );

  serial_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_en), .wr(tx_wr), .wdata(wdata),
    .eight(eight), .par_en(par_en), .even(even), .two_stop(two_stop),
    .line(tx_line), .hold_empty(hold_empty), .shift_idle(shift_idle), .load_evt(tx_load)
  );

  serial_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .rxd(rxd),
    .eight(eight), .par_en(par_en), .even(even), .rd_clr(rx_rd), .err_clr(err_clr),
    .data(rx_data), .ready(rx_ready), .fe(fe), .pe(pe), .oe(oe),
    .complete_evt(rx_complete), .overrun_evt(overrun_evt)
  );

  assign tx_ready = hold_empty;
  assign tx_empty = hold_empty && shift_idle;
  assign status   = {dsr_i, 1'b0, fe, oe, pe, tx_empty, rx_ready, tx_ready};

  always_comb begin
    case (addr)
      A_DATA:  rdata = rx_data;
      A_STAT:  rdata = status;
      A_CMD:   rdata = {2'b00, rts_q, 1'b0, brk, rx_en, dtr_q, tx_en};
      default: rdata = {4'h0, rate_q};
    endcase
  end

  assign txd   = brk ? 1'b0 : tx_line;
  assign rts_o = rts_q;
  assign dtr_o = dtr_q;
  assign irq_o = rx_ready;
endmodule

// File: rtl/serial_port_checker.sv
module serial_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       brk,
  input logic       tx_empty,
  input logic       tx_ready,
  input logic       tx_wr,
  input logic       tx_load,
  input logic       rx_rd,
  input logic       rx_complete,
  input logic       rx_ready,
  input logic       overrun_evt,
  input logic [7:0] rx_data,
  input logic       err_clr,
  input logic       fe,
  input logic       pe,
  input logic       oe
);
  p_idle_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd);

  p_load_frees_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_wr) |=> tx_ready);

  p_read_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_complete) |=> !rx_ready);

  p_complete_sets_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |=> rx_ready);

  p_overrun_keeps_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !err_clr) |=> ($stable(rx_data) && oe));

  p_clear_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !(fe || pe || oe));
endmodule

bind async_serial_port serial_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .brk(brk), .tx_empty(tx_empty),
  .tx_ready(tx_ready), .tx_wr(tx_wr), .tx_load(tx_load), .rx_rd(rx_rd),
  .rx_complete(rx_complete), .rx_ready(rx_ready), .overrun_evt(overrun_evt),
  .rx_data(rx_data), .err_clr(err_clr), .fe(fe), .pe(pe), .oe(oe)
);

// File: tb/tb_async_serial_port.sv
module tb_async_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 1_228_800;
  localparam int WATCHDOG = 190_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd;
  logic       dsr_i = 1'b0;
  logic       rts_o, dtr_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int bit_cyc = 32;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_serial_port #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .dsr_i(dsr_i),
    .rts_o(rts_o), .dtr_o(dtr_o), .irq_o(irq_o)
  );

  function automatic int rate_of(input int code);
    int t [13] = '{110, 150, 300, 600, 1200, 2400, 4800, 9600, 1200, 75, 19200, 38400, 200};
    return (code < 13) ? t[code] : 9600;
  endfunction

  function automatic int cycles_per_bit(input int code);
    int r = rate_of(code);
    return 16 * ((CLK_HZ + 8 * r) / (16 * r));
  endfunction

  function automatic logic [11:0] mk_frame(input logic [7:0] d, input int nd,
      input bit use_par, input bit par_val, input bit stop_val, output int n);
    logic [11:0] f = '1;
    int k;
    f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[1+i] = d[i];
    k = 1 + nd;
    if (use_par) begin f[k] = par_val; k++; end
    f[k] = stop_val;
    n = k + 1;
    return f;
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_rate(input int code);
    bus_write(2'd3, 8'(code));
    bit_cyc = cycles_per_bit(code);
  endtask

  task automatic send_rx(input logic [11:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = f[i];
      repeat (bit_cyc) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bit_cyc) @(negedge clk);
  endtask

  task automatic capture_tx(input int n, output logic [11:0] f);
    f = '1;
    while (txd) @(negedge clk);
    repeat (bit_cyc / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      f[i] = txd;
      repeat (bit_cyc) @(negedge clk);
    end
  endtask

  task automatic wait_tx_empty();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      bus_read(2'd1, s);
      if (s[2]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check_eq("R1", "txd", txd, 1);
    check_eq("R1", "irq", irq_o, 0);
    check_eq("R1", "rts/dtr", {rts_o, dtr_o}, 0);
    bus_read(2'd1, s);
    check_eq("R1", "status", s, 8'h05);
  endtask

  task automatic t_modem();
    logic [7:0] s;
    bus_write(2'd2, 8'h22);
    check_eq("R12", "rts/dtr", {rts_o, dtr_o}, 2'b11);
    dsr_i = 1'b1;
    bus_read(2'd1, s);
    check_eq("R12", "dsr bit7 set", s[7], 1);
    dsr_i = 1'b0;
    bus_read(2'd1, s);
    check_eq("R12", "dsr bit7 clear", s[7], 0);
    bus_write(2'd2, 8'h00);
    check_eq("R12", "rts/dtr off", {rts_o, dtr_o}, 2'b00);
  endtask

  task automatic t_tx_enable_hold();
    logic [7:0] s; logic [11:0] f, e; int n; int lows = 0;
    bus_write(2'd1, 8'h04);
    bus_write(2'd0, 8'h5A);
    bus_read(2'd1, s);
    check_eq("R5", "ready/empty while held", {s[2], s[0]}, 2'b00);
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!txd) lows++; end
    check_eq("R6", "txd quiet while disabled", lows, 0);
    bus_write(2'd2, 8'h01);
    bus_read(2'd1, s);
    check_eq("R5", "ready set, not empty", {s[2], s[0]}, 2'b01);
    e = mk_frame(8'h5A, 8, 0, 0, 1, n);
    capture_tx(n - 1, f);
    check_eq("R3", "8N1 frame", f[9:0], e[9:0]);
    wait_tx_empty();
    bus_read(2'd1, s);
    check_eq("R5", "idle status", s & 8'h07, 8'h05);
  endtask

  task automatic t_tx_parity(input bit even_p);
    logic [11:0] f, e; int n;
    bus_write(2'd1, even_p ? 8'h30 : 8'h10);
    e = mk_frame(8'h53, 7, 1, even_p ? ^(7'h53) : ~^(7'h53), 1, n);
    bus_write(2'd0, 8'h53);
    capture_tx(n, f);
    check_eq("R4", even_p ? "7E1 frame" : "7O1 frame", f[9:0], e[9:0]);
    wait_tx_empty();
  endtask

  task automatic t_tx_two_stop();
    logic [7:0] s; logic [11:0] f;
    bus_write(2'd1, 8'h84);
    bus_write(2'd0, 8'hFF);
    capture_tx(10, f);
    check_eq("R3", "stop1 high", f[9], 1);
    bus_read(2'd1, s);
    check_eq("R3", "busy in second stop", s[2], 0);
    wait_tx_empty();
    bus_write(2'd1, 8'h04);
  endtask

  task automatic t_break();
    bus_write(2'd2, 8'h09);
    @(negedge clk);
    check_eq("R7", "txd low on break", txd, 0);
    repeat (100) @(negedge clk);
    check_eq("R7", "txd still low", txd, 0);
    bus_write(2'd2, 8'h01);
    check_eq("R7", "txd released", txd, 1);
  endtask

  task automatic t_rx_basic();
    logic [7:0] s, d; logic [11:0] f; int n;
    bus_write(2'd2, 8'h05);
    f = mk_frame(8'h3C, 8, 0, 0, 1, n);
    send_rx(f, n);
    bus_read(2'd1, s);
    check_eq("R8", "rx ready", s[1], 1);
    check_eq("R8", "irq high", irq_o, 1);
    bus_read(2'd0, d);
    check_eq("R8", "rx byte", d, 8'h3C);
    bus_read(2'd1, s);
    check_eq("R8", "ready cleared", s[1], 0);
    check_eq("R8", "irq cleared", irq_o, 0);
    bus_write(2'd1, 8'h00);
    f = mk_frame(8'hC1, 7, 0, 0, 1, n);
    send_rx(f, n);
    bus_read(2'd0, d);
    check_eq("R8", "7-bit byte", d, 8'h41);
    bus_write(2'd1, 8'h04);
  endtask

  task automatic t_overrun_clear();
    logic [7:0] s, d; logic [11:0] f; int n;
    f = mk_frame(8'h11, 8, 0, 0, 1, n);
    send_rx(f, n);
    f = mk_frame(8'h22, 8, 0, 0, 1, n);
    send_rx(f, n);
    bus_read(2'd1, s);
    check_eq("R9", "overrun flag", s[4], 1);
    bus_read(2'd0, d);
    check_eq("R9", "first byte kept", d, 8'h11);
    bus_write(2'd2, 8'h15);
    bus_read(2'd1, s);
    check_eq("R11", "flags cleared", s[5:3], 3'b000);
    bus_read(2'd2, d);
    check_eq("R11", "clear bit not stored", d[4], 0);
  endtask

  task automatic t_framing();
    logic [7:0] s, d; logic [11:0] f; int n;
    f = mk_frame(8'h55, 8, 0, 0, 0, n);
    send_rx(f, n);
    bus_read(2'd1, s);
    check_eq("R10", "framing flag", s[5], 1);
    bus_read(2'd0, d);
    bus_write(2'd2, 8'h15);
  endtask

  task automatic t_rx_parity();
    logic [7:0] s, d; logic [11:0] f; int n;
    bus_write(2'd1, 8'h34);
    f = mk_frame(8'h0F, 8, 1, 0, 1, n);
    send_rx(f, n);
    bus_read(2'd1, s);
    check_eq("R4", "good parity no flag", s[3], 0);
    bus_read(2'd0, d);
    check_eq("R4", "byte with parity", d, 8'h0F);
    f = mk_frame(8'h0F, 8, 1, 1, 1, n);
    send_rx(f, n);
    bus_read(2'd1, s);
    check_eq("R4", "parity error flag", s[3], 1);
    check_eq("R10", "no framing on good stop", s[5], 0);
    bus_read(2'd0, d);
    bus_write(2'd2, 8'h15);
    bus_write(2'd1, 8'h04);
  endtask

  task automatic t_rx_disabled();
    logic [7:0] s; logic [11:0] f; int n;
    bus_write(2'd2, 8'h01);
    f = mk_frame(8'h77, 8, 0, 0, 1, n);
    send_rx(f, n);
    bus_read(2'd1, s);
    check_eq("R13", "no ready when disabled", s[1], 0);
    check_eq("R13", "no irq when disabled", irq_o, 0);
  endtask

  task automatic t_rate(input int code);
    int cnt = 0;
    set_rate(code);
    bus_write(2'd0, 8'h02);
    while (txd) @(negedge clk);
    while (!txd) @(negedge clk);
    while (txd) begin cnt++; @(negedge clk); end
    check_eq("R2", $sformatf("bit cycles code %0d", code), cnt, cycles_per_bit(code));
    set_rate(11);
    wait_tx_empty();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modem();
    set_rate(11);
    t_tx_enable_hold();
    t_tx_parity(1'b1);
    t_tx_parity(1'b0);
    t_tx_two_stop();
    t_break();
    t_rx_basic();
    t_overrun_clear();
    t_framing();
    t_rx_parity();
    t_rx_disabled();
    t_rate(10);
    t_rate(8);
    t_rate(9);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule